// File: doc/BRIEF.md
# Interrupt Priority Threshold Mask

This block sits between a set of eight active-low interrupt request lines and a processor's single level-sensitive interrupt input. It finds the most urgent active request (line 0 is the most urgent, line 7 the least) and presents that line's number, already multiplied by two, on a read port. The processor can use that value directly as a byte offset into a table of two-byte handler addresses.

A 4-bit threshold register can be written by the processor. The interrupt output is driven low only when a request is active and its line number is strictly below the stored threshold. A long handler can lower the threshold to its own level, so that more urgent requests still get through while less urgent ones wait. The requests are captured in a register each cycle, so the read port never shows a value that is still changing. The interrupt output and the read port are registered together and always describe the same capture.

Top module: `ipm_irq_threshold`

## Requirements
- R1: After reset the threshold is 0, `irq_n` is 1, and `rd_data` reads 0x0E.
- R2: A cycle with `cs` and `we` both high loads `wr_data` into the threshold at that clock edge. The interrupt output reflects the new threshold at the following edge.
- R3: `irq_n` is 0 only when at least one request is active and the most urgent active line number L satisfies L < threshold. Otherwise it is 1.
- R4: With threshold 8, every one of the eight lines raises the interrupt, line 7 included.
- R5: With threshold 5, lines 0 to 4 raise the interrupt and lines 5 to 7 do not. With threshold 3, only lines 0 to 2 raise it.
- R6: With threshold 0, no request raises the interrupt.
- R7: Threshold values 9 to 15 behave exactly like 8.
- R8: `rd_data` holds L in bits 3..1, with bit 0 and bits 7..4 at zero, whatever the threshold is. When no line is active it reads 0x0E.
- R9: A cycle with `cs` low or `we` low leaves the threshold unchanged.
- R10: A level on `req_n` present before clock edge k appears on `irq_n` and `rd_data` after edge k+1. Both outputs come straight from registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_n | input | 8 | Interrupt requests, active low, line 0 most urgent |
| cs | input | 1 | Chip select for the threshold write |
| we | input | 1 | Write strobe for the threshold |
| wr_data | input | 4 | Threshold value to load |
| irq_n | output | 1 | Gated interrupt to the processor, active low |
| rd_data | output | 8 | Most urgent active line times two |

## Verification
The hardest case to reach is the moment a threshold write lands while a request is already pending. The interrupt must change exactly one edge after the write and never flicker. Requests that sit just above and just below the threshold (4/5 and 2/3) must land on the correct side. The stimulus holds a request steady, rewrites the threshold across it, and checks the output cycle by cycle. A long pseudo-random run then mixes threshold writes, writes blocked by a missing strobe or select, and changing request patterns against a behavioural model on every clock.

// File: rtl/ipm_pkg.sv
package ipm_pkg;
  localparam int unsigned IPM_LINES = 8;
  localparam int unsigned IPM_BUS_W = 8;

  typedef enum logic {
    IRQ_ACTIVE = 1'b0,
    IRQ_QUIET  = 1'b1
  } irq_level_e;
endpackage

// File: rtl/ipm_rst_sync.sv
module ipm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/ipm_prio_enc.sv
module ipm_prio_enc #(
  parameter int unsigned LINES = 8,
  localparam int unsigned LVL_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] req,
  output logic             any_o,
  output logic [LVL_W-1:0] lvl_o
);
  always_comb begin
    any_o = 1'b0;
    lvl_o = LVL_W'(LINES - 1);
    for (int i = LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        any_o = 1'b1;
        lvl_o = LVL_W'(i);
      end
    end
  end

  // R8: the reported line is set, and nothing more urgent is set
  always_comb begin
    if (any_o) begin
      assert_enc_winner_R8: assert (req[lvl_o] &&
        ((req & ((LINES'(1) << lvl_o) - LINES'(1))) == '0));
    end
  end
endmodule

// File: rtl/ipm_thr_reg.sv
module ipm_thr_reg #(
  parameter int unsigned THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             we,
  input  logic [THR_W-1:0] wr_data,
  output logic [THR_W-1:0] thr_o
);
  logic [THR_W-1:0] thr_q;
  logic [THR_W-1:0] thr_d;
  logic             load_en;

  always_comb begin
    load_en = cs & we;
    thr_d   = thr_q;
    if (load_en) thr_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else        thr_q <= thr_d;
  end

  assign thr_o = thr_q;

  assert_thr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we) |=> (thr_q == $past(wr_data)));

  assert_thr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && we) |=> $stable(thr_q));
endmodule

// File: rtl/ipm_gate.sv
module ipm_gate #(
  parameter int unsigned LINES = 8,
  parameter int unsigned BUS_W = 8,
  localparam int unsigned LVL_W = $clog2(LINES),
  localparam int unsigned THR_W = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_act,
  input  logic [THR_W-1:0] thr,
  output logic             irq_n,
  output logic [BUS_W-1:0] rd_data
);
  import ipm_pkg::*;

  localparam logic [BUS_W-1:0] IDLE_WORD = BUS_W'((LINES - 1) * 2);

  logic             any_w;
  logic [LVL_W-1:0] lvl_w;
  logic             pass_w;
  irq_level_e       irq_d, irq_q;
  logic [BUS_W-1:0] rd_d, rd_q;

  ipm_prio_enc #(.LINES(LINES)) u_enc (
    .req   (req_act),
    .any_o (any_w),
    .lvl_o (lvl_w)
  );

  always_comb begin
    pass_w = any_w && (THR_W'(lvl_w) < thr);
    irq_d  = pass_w ? IRQ_ACTIVE : IRQ_QUIET;
    rd_d   = '0;
    rd_d[LVL_W:1] = lvl_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= IRQ_QUIET;
      rd_q  <= IDLE_WORD;
    end else begin
      irq_q <= irq_d;
      rd_q  <= rd_d;
    end
  end

  assign irq_n   = irq_q;
  assign rd_data = rd_q;

  assert_irq_below_thr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n == 1'b0) |-> (THR_W'(rd_data[LVL_W:1]) < $past(thr)));

  assert_zero_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(thr) == '0) |-> irq_n);

  assert_idle_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_act) == '0) |-> (irq_n && (rd_data == IDLE_WORD)));

  assert_rd_format_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[0] == 1'b0) && (rd_data[BUS_W-1:LVL_W+1] == '0));
endmodule

// File: rtl/ipm_irq_threshold.sv
module ipm_irq_threshold #(
  parameter int unsigned LINES = ipm_pkg::IPM_LINES,
  parameter int unsigned BUS_W = ipm_pkg::IPM_BUS_W,
  localparam int unsigned THR_W = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_n,
  input  logic             cs,
  input  logic             we,
  input  logic [THR_W-1:0] wr_data,
  output logic             irq_n,
  output logic [BUS_W-1:0] rd_data
);
  logic             core_rst_n;
  logic [LINES-1:0] cap_q;
  logic [LINES-1:0] cap_d;
  logic [THR_W-1:0] thr_w;

  ipm_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (core_rst_n)
  );

  always_comb begin
    cap_d = ~req_n;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) cap_q <= '0;
    else             cap_q <= cap_d;
  end

  ipm_thr_reg #(.THR_W(THR_W)) u_thr (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .cs      (cs),
    .we      (we),
    .wr_data (wr_data),
    .thr_o   (thr_w)
  );

  ipm_gate #(.LINES(LINES), .BUS_W(BUS_W)) u_gate (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .req_act (cap_q),
    .thr     (thr_w),
    .irq_n   (irq_n),
    .rd_data (rd_data)
  );

  assert_capture_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    1'b1 |=> (cap_q == ~$past(req_n)));
endmodule

// File: tb/test_ipm_irq_threshold.sv
`timescale 1ns/1ps
module test_ipm_irq_threshold;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req_n;
  logic       cs, we;
  logic [3:0] wr_data;
  logic       irq_n;
  logic [7:0] rd_data;

  always #4 clk = ~clk;

  ipm_irq_threshold i_ipm_irq_threshold (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .cs(cs), .we(we),
    .wr_data(wr_data), .irq_n(irq_n), .rd_data(rd_data)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string cur_tag = "R1";

  // behavioural reference
  logic [7:0] m_req;
  int         m_thr;
  logic       m_irq_n;
  logic [7:0] m_rd;

  function automatic int most_urgent(logic [7:0] r);
    for (int i = 0; i < 8; i++) if (r[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 8'h00; m_thr = 0; m_irq_n = 1'b1; m_rd = 8'h0E;
    end else begin
      int l;
      l = most_urgent(m_req);
      if (l >= 0) begin
        m_irq_n = !(l < m_thr);
        m_rd    = 8'(l * 2);
      end else begin
        m_irq_n = 1'b1;
        m_rd    = 8'h0E;
      end
      m_req = ~req_n;
      if (cs && we) m_thr = int'(wr_data);
    end
  end

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irq_n/rd act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) chk(cur_tag, {irq_n, rd_data}, {m_irq_n, m_rd});
  end

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic write_thr(logic [3:0] v);
    @(negedge clk); cs = 1'b1; we = 1'b1; wr_data = v;
    @(negedge clk); cs = 1'b0; we = 1'b0;
  endtask

  task automatic put_req(logic [7:0] act_hi);
    @(negedge clk); req_n = ~act_hi;
  endtask

  task automatic expect_now(string tag, logic exp_irq, logic [7:0] exp_rd);
    chk(tag, {irq_n, rd_data}, {exp_irq, exp_rd});
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; req_n = 8'hFF; cs = 1'b0; we = 1'b0; wr_data = 4'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    cur_tag = "R1";
    expect_now("R1", 1'b1, 8'h0E);

    cur_tag = "R6";
    put_req(8'hFF); settle();
    expect_now("R6", 1'b1, 8'h00);
    for (int b = 0; b < 8; b++) begin
      put_req(8'(1 << b)); settle();
      expect_now("R6", 1'b1, 8'(b * 2));
    end

    cur_tag = "R4";
    write_thr(4'd8);
    for (int b = 0; b < 8; b++) begin
      put_req(8'(1 << b)); settle();
      expect_now("R4", 1'b0, 8'(b * 2));
    end

    cur_tag = "R5";
    write_thr(4'd5);
    put_req(8'h10); settle(); expect_now("R5", 1'b0, 8'h08);
    put_req(8'h20); settle(); expect_now("R5", 1'b1, 8'h0A);
    put_req(8'hE0); settle(); expect_now("R5", 1'b1, 8'h0A);
    write_thr(4'd3);
    put_req(8'h04); settle(); expect_now("R5", 1'b0, 8'h04);
    put_req(8'h08); settle(); expect_now("R5", 1'b1, 8'h06);

    cur_tag = "R7";
    put_req(8'h80);
    for (int v = 9; v < 16; v++) begin
      write_thr(4'(v)); settle();
      expect_now("R7", 1'b0, 8'h0E);
    end

    cur_tag = "R8";
    write_thr(4'd8);
    put_req(8'h06); settle(); expect_now("R8", 1'b0, 8'h02);
    put_req(8'hA0); settle(); expect_now("R8", 1'b0, 8'h0A);
    put_req(8'h00); settle(); expect_now("R8", 1'b1, 8'h0E);
    write_thr(4'd1);
    put_req(8'hC0); settle(); expect_now("R8", 1'b1, 8'h0C);

    cur_tag = "R9";
    write_thr(4'd8);
    put_req(8'h40); settle();
    @(negedge clk); cs = 1'b0; we = 1'b1; wr_data = 4'd0;
    @(negedge clk); cs = 1'b1; we = 1'b0;
    @(negedge clk); cs = 1'b0; we = 1'b0;
    settle(); expect_now("R9", 1'b0, 8'h0C);

    cur_tag = "R2";
    put_req(8'h08); settle(); expect_now("R2", 1'b0, 8'h06);
    @(negedge clk); cs = 1'b1; we = 1'b1; wr_data = 4'd3;
    @(negedge clk); cs = 1'b0; we = 1'b0;
    expect_now("R2", 1'b0, 8'h06);
    @(negedge clk);
    expect_now("R2", 1'b1, 8'h06);

    cur_tag = "R10";
    write_thr(4'd8);
    put_req(8'h00); settle();
    @(negedge clk); req_n = ~8'h02;
    @(negedge clk); expect_now("R10", 1'b1, 8'h0E);
    @(negedge clk); expect_now("R10", 1'b0, 8'h02);

    cur_tag = "R3";
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_n   = ~(lfsr[7:0] & {8{lfsr[9]}} | lfsr[15:8] & {8{lfsr[2] & lfsr[4]}});
      cs      = lfsr[3] & lfsr[11];
      we      = lfsr[5] | lfsr[14];
      wr_data = lfsr[12:9];
    end
    @(negedge clk); cs = 1'b0; we = 1'b0;
    settle();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule